// File: doc/BRIEF.md
# Chien-search error locator

This block finds the error bit positions of one sector from the coefficients of an error-locator polynomial over GF(2^m). Software writes the polynomial coefficients into a sigma bank, picks the field with a sector-size bit, and starts a search with a length equal to the sector's data bits plus m times the correction capability. The engine then tests one candidate position per clock cycle. For every position p with sigma(alpha^p) = 0 it stores p, 1-based, into a result bank in ascending order.

When the search ends, an event register reports that it has finished, how many roots were found, and whether the root count differs from the programmed polynomial degree. A mismatch means the sector cannot be corrected. Software turns each stored position p into byte (p-1)/8 and bit (p-1) mod 8 of the buffer. Working out sigma and flipping the buffer bits are left to software.

The register bus is word addressed, with a write strobe and a read strobe. The read data depends only on the address and is valid in the same cycle.

Top module: `chien_err_locator`

## Requirements
- R1: After reset the status, event, config and result registers all read as zero.
- R2: The config register (word 0) holds the field select in bit 0 and the polynomial degree at bit 16 upward, and reads back as written. Field select 0 uses GF(2^M0) with POLY0, the smaller-sector case; field select 1 uses GF(2^M1) with POLY1.
- R3: A write to the start register (word 1) while idle loads a search length L from the low M1 data bits. Bit 0 of the status register (word 3) then reads 1 for exactly L cycles. Afterwards bit 0 (done) of the event register (word 4) reads 1.
- R4: The search tests positions 1 to L. Every p with sigma(alpha^p) = 0 is stored, ascending, in the result bank, which starts at word 8 plus the smallest power of two that is at least T_MAX+1. Result slots beyond the number found read 0. The root count appears in event bits 12:8, and only the first T_MAX roots are stored.
- R5: Event bit 1 (uncorrectable) reads 1 after a finished search whose root count differs from the programmed degree, and 0 when the two match.
- R6: A read of the event register clears the done bit. The root count and the uncorrectable bit keep their values.
- R7: A write to the stop register (word 2) with data bit 0 = 1 aborts any search and clears busy, done, the uncorrectable bit, the root count and all result slots. The same write with bit 0 = 0 has no effect.
- R8: While a search runs, writes to the config register, the sigma bank and the start register are ignored.
- R9: A start with length 0 finds nothing and sets done on the next cycle, without entering busy.
- R10: The search uses only the coefficients at indices 0 to the programmed degree. The sigma bank (words 8 up to 8+T_MAX) may hold any other values at higher indices without changing the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (clears done on the event register) |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |

## Verification
The bench builds the block with T_MAX = 4, a small field of M0 = 4 (x^4+x+1) and a large field of M1 = 5 (x^5+x^2+1). With these fields every single-error position in both fields and every error pair of the 15-position field can be swept in full, alongside three- and four-error sets. Search lengths shorter than the largest injected position bring the root-count mismatch within easy reach. Each locator polynomial is built in the bench as a product of (1 + alpha^-p x) using its own log and antilog tables.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int unsigned GW = 16;   // widest field element handled by the helpers
  localparam int unsigned CW = 5;    // root count width
  localparam int unsigned REG_CFG  = 0;
  localparam int unsigned REG_GO   = 1;
  localparam int unsigned REG_HALT = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_EVT  = 4;
  localparam int unsigned SIG_BASE = 8;

  // shift-and-add product, reduced by poly (which carries the x^m term)
  function automatic logic [GW-1:0] gf_mul(input logic [GW-1:0] a, input logic [GW-1:0] b,
                                           input int unsigned m, input logic [GW:0] poly);
    logic [GW:0] p;
    p = '0;
    for (int i = GW - 1; i >= 0; i--) begin
      p = p << 1;
      if (p[m]) p = p ^ poly;
      if (b[i]) p = p ^ {1'b0, a};
    end
    return p[GW-1:0];
  endfunction

  function automatic logic [GW-1:0] alpha_pow(input int unsigned j, input int unsigned m,
                                              input logic [GW:0] poly);
    logic [GW-1:0] r;
    r = GW'(1);
    for (int unsigned k = 0; k < j; k++) r = gf_mul(r, GW'(2), m, poly);
    return r;
  endfunction
endpackage

// File: rtl/chien_step.sv
module chien_step import chien_pkg::*; #(
  parameter int unsigned NSIG  = 25,
  parameter int unsigned MW    = 14,
  parameter int unsigned M0    = 13,
  parameter int unsigned M1    = 14,
  parameter logic [GW:0] POLY0 = 17'h0201B,
  parameter logic [GW:0] POLY1 = 17'h04443
) (
  input  logic                     sel_i,
  input  logic [NSIG-1:0][MW-1:0]  term_i,
  output logic [NSIG-1:0][MW-1:0]  term_o,
  output logic                     root_o
);
  logic [NSIG-1:0] unused_hi;

  for (genvar j = 0; j < NSIG; j++) begin : g_term
    localparam logic [GW-1:0] K0 = alpha_pow(j, M0, POLY0);
    localparam logic [GW-1:0] K1 = alpha_pow(j, M1, POLY1);
    logic [GW-1:0] prod;
    // term j advances by the constant alpha^j of the selected field
    always_comb begin
      if (sel_i) prod = gf_mul(GW'(term_i[j]), K1, M1, POLY1);
      else       prod = gf_mul(GW'(term_i[j]), K0, M0, POLY0);
    end
    assign term_o[j]    = prod[MW-1:0];
    assign unused_hi[j] = ^prod;
  end

  always_comb begin
    logic [MW-1:0] acc;
    acc = '0;
    for (int j = 0; j < NSIG; j++) acc = acc ^ term_o[j];
    root_o = (acc == '0);
  end
endmodule

// File: rtl/chien_loc_bank.sv
module chien_loc_bank import chien_pkg::*; #(
  parameter int unsigned T_MAX = 24,
  parameter int unsigned PW    = 14,
  localparam int unsigned IW   = $clog2(T_MAX)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          hit_i,
  input  logic [PW-1:0] pos_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [PW-1:0] rd_pos_o,
  output logic [CW-1:0] count_o
);
  logic [T_MAX-1:0][PW-1:0] loc_q;
  logic [CW-1:0]            cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      loc_q <= '0;
      cnt_q <= '0;
    end else if (hit_i) begin
      if (int'(cnt_q) < T_MAX) loc_q[cnt_q[IW-1:0]] <= pos_i;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_pos_o = (int'(rd_idx_i) < T_MAX) ? loc_q[rd_idx_i] : '0;
  assign count_o  = cnt_q;

  p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  p_clear_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0) && (loc_q == '0));
endmodule

// File: rtl/chien_err_locator.sv
module chien_err_locator import chien_pkg::*; #(
  parameter int unsigned T_MAX = 24,
  parameter int unsigned M0    = 13,
  parameter int unsigned M1    = 14,
  parameter logic [GW:0] POLY0 = 17'h0201B,
  parameter logic [GW:0] POLY1 = 17'h04443,
  parameter int unsigned AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o
);
  localparam int unsigned NSIG     = T_MAX + 1;
  localparam int unsigned MW       = M1;
  localparam int unsigned LW       = M1;
  localparam int unsigned DEG_W    = $clog2(NSIG);
  localparam int unsigned IW       = $clog2(T_MAX);
  localparam int unsigned LOC_BASE = SIG_BASE + (1 << DEG_W);

  logic                     sel_q, busy_q, done_q, fin_q;
  logic [DEG_W-1:0]         deg_q;
  logic [NSIG-1:0][MW-1:0]  sig_q, term_q, term_nx;
  logic [LW-1:0]            len_q, step_q, pos_nx, len_w;
  logic                     root, uncor;
  logic                     cfg_wr, go_wr, halt_wr, evt_rd, sig_hit, loc_hit, go_ok, abort;
  logic [AW-1:0]            sig_off, loc_off;
  logic [CW-1:0]            cnt;
  logic [LW-1:0]            loc_rd;
  logic                     unused_bits;

  assign cfg_wr  = bus_we_i && bus_addr_i == AW'(REG_CFG);
  assign go_wr   = bus_we_i && bus_addr_i == AW'(REG_GO);
  assign halt_wr = bus_we_i && bus_addr_i == AW'(REG_HALT);
  assign evt_rd  = bus_re_i && !bus_we_i && bus_addr_i == AW'(REG_EVT);
  assign sig_off = bus_addr_i - AW'(SIG_BASE);
  assign loc_off = bus_addr_i - AW'(LOC_BASE);
  assign sig_hit = bus_addr_i >= AW'(SIG_BASE) && bus_addr_i < AW'(SIG_BASE + NSIG);
  assign loc_hit = bus_addr_i >= AW'(LOC_BASE) && bus_addr_i < AW'(LOC_BASE + T_MAX);
  assign len_w   = bus_wdata_i[LW-1:0];
  assign abort   = halt_wr && bus_wdata_i[0];
  assign go_ok   = go_wr && !busy_q && !abort;
  assign pos_nx  = step_q + 1'b1;
  assign unused_bits = ^{bus_wdata_i, sig_off, loc_off};

  chien_step #(.NSIG(NSIG), .MW(MW), .M0(M0), .M1(M1), .POLY0(POLY0), .POLY1(POLY1)) u_step (
    .sel_i(sel_q), .term_i(term_q), .term_o(term_nx), .root_o(root)
  );

  chien_loc_bank #(.T_MAX(T_MAX), .PW(LW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(abort || go_ok),
    .hit_i(busy_q && root && !abort), .pos_i(pos_nx),
    .rd_idx_i(loc_off[IW-1:0]), .rd_pos_o(loc_rd), .count_o(cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      deg_q  <= '0;
      sig_q  <= '0;
      term_q <= '0;
      len_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (cfg_wr && !busy_q) begin
        sel_q <= bus_wdata_i[0];
        deg_q <= bus_wdata_i[16 +: DEG_W];
      end
      if (bus_we_i && sig_hit && !busy_q) sig_q[sig_off[DEG_W-1:0]] <= bus_wdata_i[MW-1:0];
      if (evt_rd) done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
        fin_q  <= 1'b0;
      end else if (go_ok) begin
        len_q  <= len_w;
        step_q <= '0;
        for (int j = 0; j < NSIG; j++) term_q[j] <= (j <= int'(deg_q)) ? sig_q[j] : '0;
        busy_q <= (len_w != '0);
        done_q <= (len_w == '0);
        fin_q  <= (len_w == '0);
      end else if (busy_q) begin
        term_q <= term_nx;
        step_q <= pos_nx;
        if (pos_nx == len_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign uncor = fin_q && (cnt != CW'(deg_q));

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == AW'(REG_CFG)) begin
      bus_rdata_o[0]              = sel_q;
      bus_rdata_o[16 +: DEG_W]    = deg_q;
    end else if (bus_addr_i == AW'(REG_STAT)) begin
      bus_rdata_o[0] = busy_q;
    end else if (bus_addr_i == AW'(REG_EVT)) begin
      bus_rdata_o[0]      = done_q;
      bus_rdata_o[1]      = uncor;
      bus_rdata_o[8 +: CW] = cnt;
    end else if (sig_hit) begin
      bus_rdata_o[MW-1:0] = sig_q[sig_off[DEG_W-1:0]];
    end else if (loc_hit) begin
      bus_rdata_o[LW-1:0] = loc_rd;
    end
  end

  p_busy_not_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_q);
  p_go_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_ok && len_w != '0) |=> busy_q && !done_q);
  p_evt_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rd && !busy_q) |=> !done_q);
  p_halt_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !busy_q && !done_q && !fin_q);
  p_sig_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && bus_we_i && sig_hit) |=> $stable(sig_q));
  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cfg_wr) |=> $stable(sel_q) && $stable(deg_q));
  p_zero_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_ok && len_w == '0) |=> done_q && !busy_q);
endmodule

// File: tb/test_chien_err_locator.sv
module test_chien_err_locator;
  localparam int T_MAX = 4;
  localparam int M0 = 4;
  localparam int M1 = 5;
  localparam int AW = 8;
  localparam logic [16:0] POLY0 = 17'h13;
  localparam logic [16:0] POLY1 = 17'h25;
  localparam int SIG_BASE = 8;
  localparam int LOC_BASE = 16;
  localparam int A_CFG = 0, A_GO = 1, A_HALT = 2, A_STAT = 3, A_EVT = 4;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_t[64];
  int log_t[64];
  int nel;

  always #10 clk = ~clk;

  chien_err_locator #(.T_MAX(T_MAX), .M0(M0), .M1(M1), .POLY0(POLY0), .POLY1(POLY1), .AW(AW))
    i_chien_err_locator (.clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
                         .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = 32'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a); re = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic build_field(input int m, input int poly);
    int v;
    nel = (1 << m) - 1;
    v = 1;
    for (int i = 0; i < nel; i++) begin
      exp_t[i] = v; log_t[v] = i;
      v = v << 1;
      if ((v >> m) & 1) v = v ^ poly;
    end
  endtask

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % nel];
  endfunction

  task automatic poll_busy(output int n);
    int st;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      rd(A_STAT, st);
      if ((st & 1) == 0) break;
      n++;
    end
  endtask

  // pos ascending, all within 1..2^m-1
  task automatic load_case(input int sel, input int npos, input int pos[4], input bit junk);
    int s[T_MAX+1];
    int c;
    build_field(sel ? M1 : M0, sel ? int'(POLY1) : int'(POLY0));
    for (int j = 0; j <= T_MAX; j++) s[j] = 0;
    s[0] = 1;
    for (int k = 0; k < npos; k++) begin
      c = exp_t[(nel - (pos[k] % nel)) % nel];
      for (int d = T_MAX; d >= 1; d--) s[d] = s[d] ^ gmul(c, s[d-1]);
    end
    wr(A_HALT, 1);
    wr(A_CFG, (npos << 16) | sel);
    for (int j = 0; j <= T_MAX; j++)
      wr(SIG_BASE + j, (junk && j > npos) ? ((j % nel) + 1) : s[j]);
  endtask

  task automatic run_case(input int sel, input int npos, input int pos[4], input int len, input bit junk);
    int nb, ev, v, ec, e;
    load_case(sel, npos, pos, junk);
    wr(A_GO, len);
    poll_busy(nb);
    chk(nb == len, "R3 busy cycles", nb, len);
    rd(A_EVT, ev);
    ec = 0;
    for (int k = 0; k < npos; k++) if (pos[k] <= len) ec++;
    chk((ev & 1) == 1, "R3 done", ev & 1, 1);
    chk(((ev >> 8) & 31) == ec, junk ? "R10 count" : "R4 count", (ev >> 8) & 31, ec);
    chk(((ev >> 1) & 1) == int'(ec != npos), "R5 uncorrectable", (ev >> 1) & 1, int'(ec != npos));
    for (int i = 0; i < T_MAX; i++) begin
      rd(LOC_BASE + i, v);
      e = (i < ec) ? pos[i] : 0;
      chk(v == e, junk ? "R10 position" : "R4 position", v, e);
    end
  endtask

  initial begin
    int v, nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(A_STAT, v);   chk(v == 0, "R1 status", v, 0);
    rd(A_EVT, v);    chk(v == 0, "R1 event", v, 0);
    rd(A_CFG, v);    chk(v == 0, "R1 config", v, 0);
    rd(LOC_BASE, v); chk(v == 0, "R1 result", v, 0);

    wr(A_CFG, (3 << 16) | 1);
    rd(A_CFG, v); chk(v == ((3 << 16) | 1), "R2 config readback", v, (3 << 16) | 1);

    // small field: every single and every pair
    for (int p = 1; p <= 15; p++) run_case(0, 1, '{p, 0, 0, 0}, 15, 1'b0);
    for (int p = 1; p <= 14; p++)
      for (int q = p + 1; q <= 15; q++) run_case(0, 2, '{p, q, 0, 0}, 15, 1'b0);
    for (int p = 1; p <= 6; p++) run_case(0, 4, '{p, p + 2, p + 5, p + 9}, 15, 1'b0);
    // large field (R2): every single, triples and quads
    for (int p = 1; p <= 31; p++) run_case(1, 1, '{p, 0, 0, 0}, 31, 1'b0);
    for (int p = 1; p <= 20; p++) run_case(1, 3, '{p, p + 5, p + 11, 0}, 31, 1'b0);
    for (int p = 1; p <= 11; p++) run_case(1, 4, '{p, p + 3, p + 9, p + 20}, 31, 1'b0);

    // R5: roots beyond the search length, and a root-free constant polynomial
    run_case(1, 3, '{4, 12, 25, 0}, 20, 1'b0);
    run_case(0, 2, '{3, 10, 0, 0}, 9, 1'b0);
    run_case(1, 0, '{0, 0, 0, 0}, 31, 1'b0);
    run_case(1, 4, '{2, 9, 18, 30}, 17, 1'b0);

    // R10: junk above the degree
    run_case(0, 1, '{6, 0, 0, 0}, 15, 1'b1);
    run_case(1, 2, '{2, 30, 0, 0}, 31, 1'b1);

    // R6: second read of the event register
    run_case(1, 1, '{7, 0, 0, 0}, 31, 1'b0);
    rd(A_EVT, v);
    chk((v & 1) == 0, "R6 done cleared", v & 1, 0);
    chk(((v >> 8) & 31) == 1, "R6 count kept", (v >> 8) & 31, 1);
    chk(((v >> 1) & 1) == 0, "R6 flag kept", (v >> 1) & 1, 0);

    // R9: zero length
    wr(A_HALT, 1); wr(A_CFG, 0); wr(A_GO, 0);
    rd(A_EVT, v); chk(v == 1, "R9 zero-length event", v, 1);
    rd(A_STAT, v); chk(v == 0, "R9 not busy", v, 0);

    // R7: stop with bit 0 clear is ignored, with bit 0 set aborts
    load_case(1, 1, '{3, 0, 0, 0}, 1'b0);
    wr(A_GO, 31);
    rd(A_STAT, v); chk(v == 1, "R7 running", v, 1);
    wr(A_HALT, 0);
    rd(A_STAT, v); chk(v == 1, "R7 stop bit0=0 ignored", v, 1);
    wr(A_HALT, 1);
    rd(A_STAT, v); chk(v == 0, "R7 stopped", v, 0);
    rd(A_EVT, v); chk(v == 0, "R7 event cleared", v, 0);
    rd(LOC_BASE, v); chk(v == 0, "R7 results cleared", v, 0);

    // R8: writes during a search are ignored
    load_case(1, 1, '{5, 0, 0, 0}, 1'b0);
    wr(A_GO, 31);
    wr(SIG_BASE, 0);
    wr(A_CFG, 0);
    wr(A_GO, 3);
    poll_busy(nb);
    chk(nb == 28, "R8 restart ignored", nb, 28);
    rd(A_EVT, v); chk(((v >> 8) & 31) == 1, "R8 count", (v >> 8) & 31, 1);
    rd(LOC_BASE, v); chk(v == 5, "R8 position", v, 5);
    rd(SIG_BASE, v); chk(v == 1, "R8 sigma kept", v, 1);
    rd(A_CFG, v); chk(v == ((1 << 16) | 1), "R8 config kept", v, (1 << 16) | 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule